// File: doc/BRIEF.md
# Digital Quadrature Mixer with Fixed-Fraction Carriers

This block sits after an interpolation chain and shifts a pair of signed sample streams up in frequency by multiplying them with carriers at one half, one quarter or one eighth of the output sample rate, or passes them through untouched. Because each carrier is a short repeating pattern of the values +1, 0, -1 and plus or minus one over root two, there is no oscillator: a three-bit phase count that advances once per accepted sample picks the carrier values from a small table.

Two output forms are offered. In the real form each channel is mixed with its own carrier (the first with cosine, the second with sine), which suits two independent converters. In the complex form the two streams are combined as one complex signal, which produces the sum and difference terms needed by an image-rejecting upconverter. The complex sum can exceed full scale by about 3 dB, so every result is rounded and clamped to the 16-bit signed range instead of being allowed to wrap. A change of carrier or output form restarts the carrier at phase zero so that the two carriers always start aligned.

Top module: `qmod_mixer`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high; `out_i` and `out_q` change only then and otherwise hold their value; after reset all outputs are zero.
- R2: With `freq_sel` = 0 the block bypasses mixing: `out_i` equals the `in_i` sample and `out_q` equals the `in_q` sample, whatever `cplx_en` is.
- R3: `freq_sel` encodes 0 = none, 1 = fs/2, 2 = fs/4, 3 = fs/8; the phase index n starts at 0 and advances by one (modulo 8) for every sample accepted with `in_valid` high.
- R4: At fs/2 the cosine carrier is +1 for even n and -1 for odd n, and the sine carrier is 0.
- R5: At fs/4 the cosine carrier repeats +1, 0, -1, 0 and the sine carrier repeats 0, +1, 0, -1.
- R6: At fs/8 the carriers are cos(n*45 degrees) and sin(n*45 degrees), with the value one over root two represented as 23170/32768.
- R7: With `cplx_en` = 0 and a carrier selected, `out_i` = I*cos and `out_q` = Q*sin.
- R8: With `cplx_en` = 1 and a carrier selected, `out_i` = I*cos - Q*sin and `out_q` = I*sin + Q*cos.
- R9: Each output is the exact sum of products with the carrier in units of 1/32768, plus 16384, shifted right by 15 with floor, then clamped to the range -32768 to 32767 (so -32768 times -1 gives 32767).
- R10: When `freq_sel` or `cplx_en` differs from its value in the previous clock cycle, the phase restarts: a sample accepted in that cycle uses n = 0, and the next one n = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase input sample, two's complement |
| in_q | input | 16 | Quadrature input sample, two's complement |
| freq_sel | input | 2 | Carrier select: 0 none, 1 fs/2, 2 fs/4, 3 fs/8 |
| cplx_en | input | 1 | 1 = complex output form, 0 = real per-channel form |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | First output channel, two's complement |
| out_q | output | 16 | Second output channel, two's complement |

## Verification
The hardest situation to reach from the ports is a mode switch that lands in the middle of a carrier period, either in a cycle that also carries a sample or during a gap in the strobe, because the phase restart must then be told apart from ordinary modulo-8 wrap. The stimulus switches carrier and output form after odd sample counts, both with and without a sample in the switching cycle, and a long stretch with a gapped strobe and periodic mode changes follows. Clamping is reached with full-scale inputs at the fs/8 diagonal phases in complex form and with -32768 against a -1 carrier.

// File: rtl/qmod_pkg.sv
package qmod_pkg;

  // Carrier frequency selection, as a fraction of the output sample rate.
  typedef enum logic [1:0] {
    CAR_NONE    = 2'd0,
    CAR_HALF    = 2'd1,
    CAR_QUARTER = 2'd2,
    CAR_EIGHTH  = 2'd3
  } car_sel_e;

  // Operating mode seen by the phase tracker.
  typedef struct packed {
    logic     cplx;
    car_sel_e sel;
  } mix_mode_t;

endpackage

// File: rtl/qmod_phase.sv
module qmod_phase #(
  parameter int PHW = 3,
  parameter int MW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [MW-1:0]  mode,
  output logic [PHW-1:0] eff_phase,
  output logic           mode_chg
);

  logic [PHW-1:0] phase_q;
  logic [MW-1:0]  mode_q;

  assign mode_chg  = (mode != mode_q);
  assign eff_phase = mode_chg ? '0 : phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      mode_q  <= '0;
    end else begin
      mode_q  <= mode;
      phase_q <= in_valid ? eff_phase + PHW'(1) : eff_phase;
    end
  end

  // R3: steady mode, each accepted sample moves the phase by one
  a_r3_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !mode_chg |=> phase_q == $past(phase_q) + PHW'(1));

  // R10: a mode switch restarts the carrier at phase zero
  a_r10_restart_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg && in_valid |=> phase_q == PHW'(1));

  a_r10_restart_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg && !in_valid |=> phase_q == '0);

endmodule

// File: rtl/qmod_carrier.sv
module qmod_carrier
  import qmod_pkg::*;
#(
  parameter int PHW       = 3,
  parameter int CW        = 17,
  parameter int FRAC      = 15,
  parameter int ROOT_HALF = 23170
) (
  input  car_sel_e              sel,
  input  logic [PHW-1:0]        phase,
  output logic signed [CW-1:0]  cos_c,
  output logic signed [CW-1:0]  sin_c
);

  localparam logic signed [CW-1:0] K_ONE  = CW'(2 ** FRAC);
  localparam logic signed [CW-1:0] K_MONE = -K_ONE;
  localparam logic signed [CW-1:0] K_H    = CW'(ROOT_HALF);
  localparam logic signed [CW-1:0] K_MH   = -K_H;
  localparam logic signed [CW-1:0] K_ZERO = '0;

  logic [2:0] n;
  assign n = phase[2:0];

  always_comb begin
    cos_c = K_ONE;
    sin_c = K_ZERO;
    unique case (sel)
      CAR_NONE: begin
        cos_c = K_ONE;
        sin_c = K_ZERO;
      end
      CAR_HALF: begin
        cos_c = n[0] ? K_MONE : K_ONE;
        sin_c = K_ZERO;
      end
      CAR_QUARTER: begin
        case (n[1:0])
          2'd0:    begin cos_c = K_ONE;  sin_c = K_ZERO; end
          2'd1:    begin cos_c = K_ZERO; sin_c = K_ONE;  end
          2'd2:    begin cos_c = K_MONE; sin_c = K_ZERO; end
          default: begin cos_c = K_ZERO; sin_c = K_MONE; end
        endcase
      end
      CAR_EIGHTH: begin
        case (n)
          3'd0:    begin cos_c = K_ONE;  sin_c = K_ZERO; end
          3'd1:    begin cos_c = K_H;    sin_c = K_H;    end
          3'd2:    begin cos_c = K_ZERO; sin_c = K_ONE;  end
          3'd3:    begin cos_c = K_MH;   sin_c = K_H;    end
          3'd4:    begin cos_c = K_MONE; sin_c = K_ZERO; end
          3'd5:    begin cos_c = K_MH;   sin_c = K_MH;   end
          3'd6:    begin cos_c = K_ZERO; sin_c = K_MONE; end
          default: begin cos_c = K_H;    sin_c = K_MH;   end
        endcase
      end
      default: begin
        cos_c = K_ONE;
        sin_c = K_ZERO;
      end
    endcase
  end

endmodule

// File: rtl/qmod_lane.sv
module qmod_lane #(
  parameter int DW   = 16,
  parameter int CW   = 17,
  parameter int FRAC = 15
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic signed [CW-1:0] ka,
  input  logic signed [CW-1:0] kb,
  output logic signed [DW-1:0] y,
  output logic                 sat_hit
);

  localparam int SW = DW + CW + 1;
  localparam logic signed [SW-1:0] RND = SW'(2 ** (FRAC - 1));
  localparam logic signed [SW-1:0] HI  = SW'(2 ** (DW - 1) - 1);
  localparam logic signed [SW-1:0] LO  = -HI - SW'(1);

  // Full-precision a*ka + b*kb, rounded half up and scaled down by 2^FRAC.
  function automatic logic signed [SW-1:0] mix_round(
    input logic signed [DW-1:0] x,
    input logic signed [DW-1:0] z,
    input logic signed [CW-1:0] kx,
    input logic signed [CW-1:0] kz
  );
    logic signed [SW-1:0] acc;
    acc = (SW'(x) * SW'(kx)) + (SW'(z) * SW'(kz)) + RND;
    return acc >>> FRAC;
  endfunction

  // Clamp to the signed DW-bit range.
  function automatic logic signed [DW-1:0] clamp(input logic signed [SW-1:0] v);
    if (v > HI)      return DW'(HI);
    else if (v < LO) return DW'(LO);
    else             return v[DW-1:0];
  endfunction

  logic signed [SW-1:0] wide;

  always_comb begin
    wide    = mix_round(a, b, ka, kb);
    y       = clamp(wide);
    sat_hit = (wide > HI) || (wide < LO);
  end

endmodule

// File: rtl/qmod_mixer.sv
module qmod_mixer
  import qmod_pkg::*;
#(
  parameter int DW        = 16,
  parameter int CW        = 17,
  parameter int FRAC      = 15,
  parameter int PHW       = 3,
  parameter int ROOT_HALF = 23170
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [1:0]           freq_sel,
  input  logic                 cplx_en,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int NLANE = 2;
  localparam int MW    = $bits(mix_mode_t);
  localparam logic signed [CW-1:0] K_ONE = CW'(2 ** FRAC);

  mix_mode_t      mode_w;
  logic [PHW-1:0] phase;
  logic           mode_chg;

  assign mode_w.cplx = cplx_en;
  assign mode_w.sel  = car_sel_e'(freq_sel);

  qmod_phase #(.PHW(PHW), .MW(MW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode_w),
    .eff_phase (phase),
    .mode_chg  (mode_chg)
  );

  logic signed [CW-1:0] cos_c, sin_c;

  qmod_carrier #(.PHW(PHW), .CW(CW), .FRAC(FRAC), .ROOT_HALF(ROOT_HALF)) u_carrier (
    .sel   (mode_w.sel),
    .phase (phase),
    .cos_c (cos_c),
    .sin_c (sin_c)
  );

  // Coefficient pairs per lane: lane_out = in_i*ka + in_q*kb.
  logic signed [CW-1:0] ka [NLANE];
  logic signed [CW-1:0] kb [NLANE];
  logic signed [DW-1:0] lane_y [NLANE];
  logic [NLANE-1:0]     lane_sat;

  always_comb begin
    if (mode_w.sel == CAR_NONE) begin
      ka[0] = K_ONE; kb[0] = '0;
      ka[1] = '0;    kb[1] = K_ONE;
    end else if (!cplx_en) begin
      ka[0] = cos_c; kb[0] = '0;
      ka[1] = '0;    kb[1] = sin_c;
    end else begin
      ka[0] = cos_c; kb[0] = -sin_c;
      ka[1] = sin_c; kb[1] = cos_c;
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    qmod_lane #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_lane (
      .a       (in_i),
      .b       (in_q),
      .ka      (ka[g]),
      .kb      (kb[g]),
      .y       (lane_y[g]),
      .sat_hit (lane_sat[g])
    );
  end

  // Named event for the checks below: a clamped result is being captured.
  logic clamp_evt;
  assign clamp_evt = in_valid && (|lane_sat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= lane_y[0];
        out_q <= lane_y[1];
      end
    end
  end

  // R1: one-cycle latency on the strobe
  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1: no strobe, no new output and the held value stays
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_i) && $stable(out_q));

  // R2: bypass returns the input samples unchanged
  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ($past(freq_sel) == CAR_NONE) |->
      out_i == $past(in_i) && out_q == $past(in_q));

  // R4: real form at fs/2 has a zero sine carrier
  a_r4_half_sine_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ($past(freq_sel) == CAR_HALF) && !$past(cplx_en) |-> out_q == '0);

  // R9: a clamped result lands on a range end, never wraps
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_evt |=> (out_i == DW'(2 ** (DW - 1) - 1) || out_i == DW'(2 ** (DW - 1)) ||
                   out_q == DW'(2 ** (DW - 1) - 1) || out_q == DW'(2 ** (DW - 1))));

endmodule

// File: tb/test_qmod_mixer.sv
module test_qmod_mixer;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_i = '0;
  logic signed [15:0] in_q = '0;
  logic [1:0]         freq_sel = 2'd0;
  logic               cplx_en = 1'b0;
  logic               out_valid;
  logic signed [15:0] out_i;
  logic signed [15:0] out_q;

  always #2 clk = ~clk;

  qmod_mixer i_qmod_mixer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .freq_sel(freq_sel), .cplx_en(cplx_en),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  typedef struct {
    int    ei;
    int    eq;
    string tag;
  } exp_t;

  exp_t  sb[$];
  int    checks = 0;
  int    failures = 0;
  bit    mon_on = 0;
  bit    done = 0;
  int    last_i = 0, last_q = 0;
  int    m_ph = 0;
  int    m_prev_mode = 0;

  // Carrier in units of 1/32768 for an angle of k*45 degrees.
  function automatic int cos45(int k);
    case (k & 7)
      0: return 32768;   1: return 23170;  2: return 0;       3: return -23170;
      4: return -32768;  5: return -23170; 6: return 0;       default: return 23170;
    endcase
  endfunction

  function automatic int scale_clip(longint x);
    longint r;
    r = (x + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic check(string tag, int act_i, int act_q, int exp_i, int exp_q);
    checks++;
    if (act_i != exp_i || act_q != exp_q) begin
      failures++;
      $display("FAIL %s: actual i=%0d q=%0d expected i=%0d q=%0d", tag, act_i, act_q, exp_i, exp_q);
    end
  endtask

  // One clock of stimulus; the reference model follows the requirements.
  task automatic step(bit v, int si, int sq, int fs, bit cx, string tag);
    int mode, ang, c, s, ei, eq;
    longint li, lq;
    @(negedge clk);
    in_valid = v;
    in_i     = 16'(si);
    in_q     = 16'(sq);
    freq_sel = 2'(fs);
    cplx_en  = cx;
    mode = fs + (cx ? 4 : 0);
    if (mode != m_prev_mode) m_ph = 0;         // R10
    m_prev_mode = mode;
    if (v) begin
      li = longint'(in_i);
      lq = longint'(in_q);
      ang = (fs == 1) ? 4 * m_ph : (fs == 2) ? 2 * m_ph : m_ph;
      c = cos45(ang);
      s = cos45(ang + 6);                     // sin(x) = cos(x - 90)
      if (fs == 0) begin
        ei = int'(li); eq = int'(lq);
      end else if (!cx) begin
        ei = scale_clip(li * c);
        eq = scale_clip(lq * s);
      end else begin
        ei = scale_clip(li * c - lq * s);
        eq = scale_clip(li * s + lq * c);
      end
      sb.push_back('{ei, eq, tag});
      m_ph = (m_ph + 1) % 8;                  // R3
    end
  endtask

  // Monitor: pop and compare each produced sample; idle cycles must hold.
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          checks++; failures++;
          $display("FAIL R1: actual unexpected output i=%0d q=%0d expected none", out_i, out_q);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, int'(out_i), int'(out_q), e.ei, e.eq);
        end
        last_i = int'(out_i);
        last_q = int'(out_q);
      end else begin
        check("R1 hold", int'(out_i), int'(out_q), last_i, last_q);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual run still busy expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_i !== 16'sd0 || out_q !== 16'sd0) begin
      failures++;
      $display("FAIL R1 reset: actual v=%0b i=%0d q=%0d expected 0 0 0", out_valid, out_i, out_q);
    end
    mon_on = 1;

    // R2: bypass in both forms, with gaps
    step(1, 1234, -5678, 0, 0, "R2");
    step(0, 0, 0, 0, 0, "R1");
    step(1, -32768, 32767, 0, 0, "R2");
    step(1, 77, -1, 0, 1, "R2");
    step(1, -400, 900, 0, 1, "R2");
    step(0, 0, 0, 0, 1, "R1");

    // R4/R7: fs/2 real, including -32768 against -1 (R9)
    for (int k = 0; k < 6; k++) step(1, 1000 * k - 2500, 300 + k, 1, 0, "R4");
    step(1, 5, 5, 1, 0, "R4");
    step(1, -32768, -32768, 1, 0, "R9 clamp");

    // R5: fs/4 real and complex
    for (int k = 0; k < 8; k++) step(1, 3000 + k, -2000 + 7 * k, 2, 0, "R5");
    for (int k = 0; k < 8; k++) step(1, 12000 - 3 * k, 8000 + k, 2, 1, "R8");

    // R6: fs/8 real, two full periods
    for (int k = 0; k < 16; k++) step(1, 20000 - 1500 * k, -7000 + 900 * k, 3, 0, "R6");
    // R8/R9: fs/8 complex with full-scale inputs at diagonal phases
    for (int k = 0; k < 8; k++) step(1, 32767, 32767, 3, 1, "R9 complex");
    for (int k = 0; k < 8; k++) step(1, -32768, 32767, 3, 1, "R9 complex");

    // R10: mode switch mid-period, with and without a sample in that cycle
    step(1, 10000, 2000, 3, 1, "R10");
    step(1, 10000, 2000, 3, 1, "R10");
    step(1, 10000, 2000, 3, 1, "R10");
    step(1, 10000, 2000, 3, 0, "R10 switch with sample");
    step(1, 10000, 2000, 3, 0, "R10");
    step(0, 0, 0, 2, 0, "R10");
    step(1, 10000, 2000, 2, 0, "R10 after idle switch");
    step(1, 10000, 2000, 2, 0, "R10");
    step(1, 10000, 2000, 2, 0, "R10");
    step(0, 0, 0, 2, 1, "R10");
    step(0, 0, 0, 2, 1, "R10");
    step(1, -9000, 4000, 2, 1, "R10 after idle switch");
    step(1, -9000, 4000, 2, 1, "R10");

    // R3: gapped strobe with periodic mode changes and varied data
    for (int k = 0; k < 400; k++) begin
      int fs;
      bit cx;
      fs = (k / 37) % 4;
      cx = ((k / 53) % 2) == 1;
      step(($urandom % 4) != 0, int'($urandom % 65536) - 32768,
           int'($urandom % 65536) - 32768, fs, cx, "R3 stream");
    end

    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, "R1");
    @(negedge clk);
    // R1: every pushed sample was produced
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R1: actual %0d samples missing expected 0", sb.size());
    end
    done = 1;
    finish_run();
  end

endmodule